// File: doc/BRIEF.md
# RTC Periodic Interrupt and Square-Wave Generator

This block is the periodic-event part of a real-time-clock register set. It runs directly on the 32.768 kHz time base, so one `clk` cycle is one time-base cycle. Three byte-wide registers are reachable through a simple read/write port. The rate register holds a 4-bit rate code in its low nibble. The control register holds the enable bits. The flag register holds the interrupt flags and is read-only.

A programmable divider turns the rate code into a periodic tick. On each tick the block can latch flags and hold the interrupt line high until software reads the flag register. On the same tick it can also emit a one-cycle pulse on a separate square-wave output. The two enables gate their own outputs independently. The divider runs when either enable is set.

Writing the rate or the control register restarts the divider from zero, so a new rate applies at once. Reading the flag register returns the flags and clears them.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset the rate register (address 0) reads 0x26, the control register (address 1) reads 0x02, the flag register (address 2) reads 0x00, and `irq_o` and `sqw_o` are low.
- R2: The rate code is bits 3:0 of the rate register. For an effective code n in 3..15 the tick period is 2^(n-1) clock cycles. The first tick lands exactly one period after the clock edge that accepts a write to address 0 or 1, because such a write restarts the divider from zero.
- R3: Rate codes 1 and 2 are treated as codes 8 and 9, giving periods of 128 and 256 cycles.
- R4: A rate code of 0 stops the divider: no ticks, no flags and no square-wave pulses.
- R5: With both control bit 6 (periodic interrupt enable) and control bit 3 (square-wave enable) clear, no tick occurs for any rate code.
- R6: A tick with control bit 6 set sets flag-register bits 7 and 6 (reads 0xC0) and raises `irq_o`. `irq_o` stays high until the flag register is read.
- R7: A tick with control bit 3 set makes `sqw_o` high for exactly one cycle. This happens whatever the state of bit 6. With bit 3 clear, `sqw_o` stays low. With bit 6 clear, the flags stay at 0.
- R8: A read of address 2 returns the flags on `rdata_o` one cycle after `rd_en_i`, and clears the flags and `irq_o`. If a tick falls on the reading edge, the read returns the old value and the flags stay set.
- R9: Writes to address 2 have no effect. Addresses 0 and 1 read back the last byte written. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe for one cycle |
| addr_i | input | 2 | Register select: 0 rate, 1 control, 2 flags, 3 unused |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Periodic interrupt, held until the flag register is read |
| sqw_o | output | 1 | One-cycle pulse per tick when square-wave output is enabled |

## Verification
The hardest case to reach is a flag-register read that lands on the very edge where a tick sets the flags. The read and the tick then race for the same flops. The stimulus reaches this case by counting cycles from the restart caused by a rate write. The fastest rate gives a 4-cycle period. The bench clears the flags with a first read and then places a second read on the fourth edge after the write. It expects the old value 0x00 on `rdata_o` and `irq_o` still high. Randomly chosen rate codes and enable mixes check spacing and first-tick latency against a period computed in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    RA_RATE = 2'd0,
    RA_CTRL = 2'd1,
    RA_FLAG = 2'd2,
    RA_NONE = 2'd3
  } rtc_addr_e;

  localparam int CTRL_PIE_BIT  = 6;
  localparam int CTRL_SQWE_BIT = 3;

  localparam logic [7:0] RATE_RST = 8'h26;
  localparam logic [7:0] CTRL_RST = 8'h02;
endpackage

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode #(
  parameter int RATE_W      = 4,
  parameter int REMAP_LIMIT = 2,
  parameter int REMAP_ADD   = 7,
  localparam int CNT_W      = (1 << RATE_W) - 1
) (
  input  logic [RATE_W-1:0] code_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  terminal_o
);
  logic [RATE_W-1:0] eff_code;

  always_comb begin
    eff_code = code_i;
    if (code_i != '0 && code_i <= RATE_W'(REMAP_LIMIT))
      eff_code = code_i + RATE_W'(REMAP_ADD);
  end

  assign active_o = (code_i != '0);

  // period 2^(n-1) -> count 0 .. 2^(n-1)-1
  always_comb begin
    terminal_o = '0;
    if (eff_code != '0)
      terminal_o = (CNT_W'(1) << (eff_code - RATE_W'(1))) - CNT_W'(1);
  end
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] terminal_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && !restart_i && (cnt_q == terminal_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i || !run_i) cnt_q <= '0;
    else if (tick_o)                cnt_q <= '0;
    else                            cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0)); // R5

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_i,
  input  logic       clr_i,
  output logic [1:0] flags_o,
  output logic       irq_o
);
  logic [1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst)        flags_q <= 2'b00;
    else if (set_i) flags_q <= 2'b11;
    else if (clr_i) flags_q <= 2'b00;
  end

  assign flags_o = flags_q;
  assign irq_o   = flags_q[1];

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_i) |=> irq_o); // R6

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_o); // R8
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int DATA_W      = 8,
  parameter int RATE_W      = 4,
  parameter int REMAP_LIMIT = 2,
  parameter int REMAP_ADD   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sqw_o
);
  import rtc_pkg::*;

  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [DATA_W-1:0] rate_q, ctrl_q, rdata_q;
  logic              sqw_q;
  logic              restart, rate_active, run, tick, pie, sqwe;
  logic              flag_set, flag_clr, irq_int;
  logic [CNT_W-1:0]  terminal;
  logic [1:0]        flags;

  assign pie     = ctrl_q[CTRL_PIE_BIT];
  assign sqwe    = ctrl_q[CTRL_SQWE_BIT];
  assign restart = wr_en_i && (addr_i == RA_RATE || addr_i == RA_CTRL);

  // register writes (flag register is read-only)
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= DATA_W'(RATE_RST);
      ctrl_q <= DATA_W'(CTRL_RST);
    end else if (wr_en_i) begin
      if (addr_i == RA_RATE) rate_q <= wdata_i;
      if (addr_i == RA_CTRL) ctrl_q <= wdata_i;
    end
  end

  rtc_rate_decode #(
    .RATE_W(RATE_W), .REMAP_LIMIT(REMAP_LIMIT), .REMAP_ADD(REMAP_ADD)
  ) u_decode (
    .code_i(rate_q[RATE_W-1:0]),
    .active_o(rate_active),
    .terminal_o(terminal)
  );

  assign run = rate_active && (pie || sqwe);

  rtc_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .run_i(run), .restart_i(restart),
    .terminal_i(terminal), .tick_o(tick)
  );

  assign flag_set = tick && pie;
  assign flag_clr = rd_en_i && (addr_i == RA_FLAG);

  rtc_flag_reg u_flags (
    .clk(clk), .rst(rst), .set_i(flag_set), .clr_i(flag_clr),
    .flags_o(flags), .irq_o(irq_int)
  );

  always_ff @(posedge clk) begin
    if (rst) sqw_q <= 1'b0;
    else     sqw_q <= tick && sqwe;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en_i) begin
      case (addr_i)
        RA_RATE: rdata_q <= rate_q;
        RA_CTRL: rdata_q <= ctrl_q;
        RA_FLAG: rdata_q <= {flags, {(DATA_W-2){1'b0}}};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_int;
  assign sqw_o   = sqw_q;

  AST_SQW_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sqw_o |=> !sqw_o); // R7

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (rst)
    !sqwe |=> !sqw_o); // R7

  AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (rst)
    (rate_q[RATE_W-1:0] == '0) |=> !sqw_o); // R4

  AST_FLAG_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == RA_FLAG && !rd_en_i && !pie) |=> $stable(irq_o)); // R9
endmodule

// File: tb/rtc_periodic_gen_tb.sv
module rtc_periodic_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sqw;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_periodic_gen dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sqw_o(sqw)
  );

  function automatic int period_of(input int code);
    int n;
    if (code == 0) return 0;
    n = (code <= 2) ? code + 7 : code;
    return 1 << (n - 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // called right after a write to A: expects pulses at cycle p and 2p
  task automatic measure_sqw(input int p, input string req);
    int first = -1, second = -1, highs = 0;
    for (int k = 1; k <= 2 * p + 1; k++) begin
      @(negedge clk);
      if (sqw) begin
        highs++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check({req, " first pulse latency"}, first, p);
    check({req, " pulse spacing"}, second - first, p);
    check({req, " pulse count/width"}, highs, 2);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    check("R1 irq", irq, 0);
    check("R1 sqw", sqw, 0);
    rd(2'd0, v); check("R1 rate reg", v, 8'h26);
    rd(2'd1, v); check("R1 ctrl reg", v, 8'h02);
    rd(2'd2, v); check("R1 flag reg", v, 8'h00);

    // R2/R7: square wave only, fastest rate
    wr(2'd1, 8'h08); wr(2'd0, 8'h03);
    measure_sqw(4, "R2 code3");
    check("R7 irq stays low without PIE", irq, 0);
    rd(2'd2, v); check("R7 flags stay clear", v, 8'h00);

    // R3 remapped codes
    wr(2'd0, 8'h01); measure_sqw(128, "R3 code1");
    wr(2'd0, 8'h02); measure_sqw(256, "R3 code2");
    wr(2'd0, 8'h0F); measure_sqw(16384, "R2 code15");

    // R2/R6 random codes and enable mixes
    for (int t = 0; t < 6; t++) begin
      int code;
      logic [7:0] b;
      code = 3 + int'($urandom % 10);
      b = ($urandom % 2) ? 8'h48 : 8'h08;
      wr(2'd1, b);
      wr(2'd0, {4'($urandom), 4'(code)});
      measure_sqw(period_of(code), "R2 random");
      rd(2'd2, v);
      check("R6 flags after ticks", v, b[6] ? 8'hC0 : 8'h00);
      check("R8 irq cleared by read", irq, 0);
    end

    // R6 PIE only: irq rises at p, held, no sqw
    begin
      int rise = -1, highs = 0;
      wr(2'd1, 8'h40); wr(2'd0, 8'h04);
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (irq && rise < 0) rise = k;
        if (sqw) highs++;
      end
      check("R6 irq latency", rise, 8);
      check("R6 irq held", irq, 1);
      check("R7 no sqw without SQWE", highs, 0);
      rd(2'd2, v); check("R6 flag value", v, 8'hC0);
      check("R8 irq low after read", irq, 0);
    end

    // R4 code 0 disables
    begin
      int ev = 0;
      wr(2'd1, 8'h48); wr(2'd0, 8'h00);
      for (int k = 0; k < 20000; k++) begin
        @(negedge clk);
        if (sqw || irq) ev++;
      end
      check("R4 code0 events", ev, 0);
      rd(2'd2, v); check("R4 code0 flags", v, 8'h00);
    end

    // R5 both enables clear
    begin
      int ev = 0;
      wr(2'd1, 8'h00); wr(2'd0, 8'h03);
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (sqw || irq) ev++;
      end
      check("R5 idle events", ev, 0);
    end

    // R9 register access
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R9 flag write ignored", v, 8'h00);
    check("R9 irq after flag write", irq, 0);
    v = 8'($urandom); wr(2'd0, v);
    begin logic [7:0] r; rd(2'd0, r); check("R9 rate readback", r, v); end
    v = 8'($urandom) & 8'hB7; wr(2'd1, v);
    begin logic [7:0] r; rd(2'd1, r); check("R9 ctrl readback", r, v); end
    rd(2'd3, v); check("R9 unused address", v, 8'h00);

    // R8 read colliding with a tick (tick on edge 4 after rate write)
    wr(2'd1, 8'h40); wr(2'd0, 8'h03);
    rd(2'd2, v);                 // read edge 2, clears
    rd(2'd2, v);                 // read edge 4, same edge as tick
    check("R8 collision read value", v, 8'h00);
    check("R8 collision keeps irq", irq, 1);
    rd(2'd2, v); check("R8 flags kept after collision", v, 8'hC0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule